// File: doc/BRIEF.md
# Single-Cycle Instruction Control Decoder

This block turns one instruction of a small 32-bit load/store instruction set into the control levels that a single-cycle datapath needs. It reads the 6-bit major opcode, the 6-bit function field that register-register instructions use, and the Zero flag that the ALU raises on an equal compare. From these 13 bits it drives the destination-register select, the register-file write enable, the ALU second-operand select, a 3-bit ALU operation code, the memory read and write strobes, the writeback-source select and the next-PC select. There is no state, so every output settles within the same cycle as its inputs.

The supported instructions are five register-register operations (add, sub, and, or, slt), load word, store word and branch-if-equal. The block decodes the final ALU operation code in one step; no separate ALU-control stage is needed. It also resolves the branch itself by gating the branch opcode with Zero. Outputs whose value does not matter for an instruction are held at 0. Any opcode outside the set, and any register-register function code outside the set, yields an all-zero control word. That word writes nothing and changes no program flow.

Top module: `insn_ctrl_dec`

## Requirements
- R1: Opcode 000000 with function code 100000 (add) gives reg_dst_o=1, reg_we_o=1, alu_src_o=0, alu_op_o=010, mem_we_o=0, mem_re_o=0, mem_to_reg_o=0, pc_sel_o=0.
- R2: Opcode 000000 selects the ALU code by function code, with all other outputs as in R1: 100010 (sub) gives 110, 100100 (and) gives 000, 100101 (or) gives 001, 101010 (slt) gives 111.
- R3: Opcode 000000 with any function code not listed in R1 or R2 drives every output to 0.
- R4: Opcode 100011 (load word) gives reg_dst_o=0, reg_we_o=1, alu_src_o=1, alu_op_o=010, mem_re_o=1, mem_we_o=0, mem_to_reg_o=1, pc_sel_o=0.
- R5: Opcode 101011 (store word) gives reg_we_o=0, alu_src_o=1, alu_op_o=010, mem_we_o=1, mem_re_o=0, with reg_dst_o, mem_to_reg_o and pc_sel_o at 0.
- R6: Opcode 000100 (branch-if-equal) gives reg_we_o=0, alu_src_o=0, alu_op_o=110, mem_we_o=0, mem_re_o=0, with reg_dst_o and mem_to_reg_o at 0.
- R7: pc_sel_o is 1 exactly when the opcode is 000100 and zero_i is 1.
- R8: Any opcode other than 000000, 100011, 101011 and 000100 drives every output to 0.
- R9: For opcodes 100011, 101011 and 000100, the function field has no effect on any output.
- R10: zero_i has no effect on any output other than pc_sel_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 6 | Major opcode field of the instruction |
| fn_i | input | 6 | Function field, decoded for register-register instructions only |
| zero_i | input | 1 | ALU equal-compare flag |
| reg_dst_o | output | 1 | 1 selects the third register field as write destination |
| reg_we_o | output | 1 | Register-file write enable |
| alu_src_o | output | 1 | 1 selects the sign-extended immediate as ALU operand B |
| alu_op_o | output | 3 | ALU operation code (000 and, 001 or, 010 add, 110 sub, 111 slt) |
| mem_we_o | output | 1 | Data-memory write strobe |
| mem_re_o | output | 1 | Data-memory read strobe |
| mem_to_reg_o | output | 1 | 1 selects memory data for register writeback |
| pc_sel_o | output | 1 | 1 selects the branch target as next PC |

## Verification
The checker's properties are evaluated only while all 13 input bits hold known values. Before that, an undriven opcode would make every relation between outputs meaningless. The bench drives every input from its first clock onward and never releases them to X or Z. It then walks the complete space of opcode, function field and Zero, so each property is evaluated on every legal combination. Outputs are compared half a cycle after each change, which gives the combinational decode time to settle.

// File: rtl/insn_ctrl_pkg.sv
package insn_ctrl_pkg;

   localparam int OP_W  = 6;
   localparam int FN_W  = 6;
   localparam int AOP_W = 3;

   // major opcodes
   localparam logic [OP_W-1:0] OPC_RR  = 6'b000000;
   localparam logic [OP_W-1:0] OPC_LD  = 6'b100011;
   localparam logic [OP_W-1:0] OPC_ST  = 6'b101011;
   localparam logic [OP_W-1:0] OPC_BEQ = 6'b000100;

   // function codes of the register-register group
   localparam logic [FN_W-1:0] FN_ADD = 6'b100000;
   localparam logic [FN_W-1:0] FN_SUB = 6'b100010;
   localparam logic [FN_W-1:0] FN_AND = 6'b100100;
   localparam logic [FN_W-1:0] FN_OR  = 6'b100101;
   localparam logic [FN_W-1:0] FN_SLT = 6'b101010;

   // ALU operation codes
   localparam logic [AOP_W-1:0] AOP_AND = 3'b000;
   localparam logic [AOP_W-1:0] AOP_OR  = 3'b001;
   localparam logic [AOP_W-1:0] AOP_ADD = 3'b010;
   localparam logic [AOP_W-1:0] AOP_SUB = 3'b110;
   localparam logic [AOP_W-1:0] AOP_SLT = 3'b111;

   typedef enum logic [2:0] {
      CLS_NONE   = 3'd0,
      CLS_RR     = 3'd1,
      CLS_LOAD   = 3'd2,
      CLS_STORE  = 3'd3,
      CLS_BRANCH = 3'd4
   } iclass_e;

   typedef struct packed {
      logic              reg_dst;
      logic              reg_we;
      logic              alu_src;
      logic [AOP_W-1:0]  alu_op;
      logic              mem_we;
      logic              mem_re;
      logic              mem_to_reg;
      logic              pc_sel;
   } ctrl_t;

endpackage

// File: rtl/insn_class_dec.sv
module insn_class_dec
   import insn_ctrl_pkg::*;
#(
   parameter int OPW = OP_W
) (
   input  logic [OPW-1:0] op_i,
   output iclass_e        cls_o
);

   if (OPW != OP_W) begin : g_bad_opw
      $error("insn_class_dec: OPW must equal the encoded opcode width");
   end

   always_comb begin
      unique case (op_i)
         OPC_RR:  cls_o = CLS_RR;
         OPC_LD:  cls_o = CLS_LOAD;
         OPC_ST:  cls_o = CLS_STORE;
         OPC_BEQ: cls_o = CLS_BRANCH;
         default: cls_o = CLS_NONE;
      endcase
   end

endmodule

// File: rtl/insn_alu_sel.sv
module insn_alu_sel
   import insn_ctrl_pkg::*;
#(
   parameter int FNW  = FN_W,
   parameter int AOPW = AOP_W
) (
   input  iclass_e         cls_i,
   input  logic [FNW-1:0]  fn_i,
   output logic [AOPW-1:0] alu_op_o,
   output logic            fn_ok_o
);

   if (FNW != FN_W) begin : g_bad_fnw
      $error("insn_alu_sel: FNW must equal the encoded function width");
   end
   if (AOPW != AOP_W) begin : g_bad_aopw
      $error("insn_alu_sel: AOPW must equal the ALU code width");
   end

   logic [AOPW-1:0] rr_op;
   logic            rr_ok;

   // function-field decode, used only by the register-register group
   always_comb begin
      rr_ok = 1'b1;
      unique case (fn_i)
         FN_ADD:  rr_op = AOP_ADD;
         FN_SUB:  rr_op = AOP_SUB;
         FN_AND:  rr_op = AOP_AND;
         FN_OR:   rr_op = AOP_OR;
         FN_SLT:  rr_op = AOP_SLT;
         default: begin
            rr_op = '0;
            rr_ok = 1'b0;
         end
      endcase
   end

   always_comb begin
      unique case (cls_i)
         CLS_RR: begin
            alu_op_o = rr_op;
            fn_ok_o  = rr_ok;
         end
         CLS_LOAD, CLS_STORE: begin
            alu_op_o = AOP_ADD;
            fn_ok_o  = 1'b1;
         end
         CLS_BRANCH: begin
            alu_op_o = AOP_SUB;
            fn_ok_o  = 1'b1;
         end
         default: begin
            alu_op_o = '0;
            fn_ok_o  = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/insn_ctrl_dec.sv
module insn_ctrl_dec
   import insn_ctrl_pkg::*;
#(
   parameter int OPW  = OP_W,
   parameter int FNW  = FN_W,
   parameter int AOPW = AOP_W
) (
   input  logic [OPW-1:0]  op_i,
   input  logic [FNW-1:0]  fn_i,
   input  logic            zero_i,
   output logic            reg_dst_o,
   output logic            reg_we_o,
   output logic            alu_src_o,
   output logic [AOPW-1:0] alu_op_o,
   output logic            mem_we_o,
   output logic            mem_re_o,
   output logic            mem_to_reg_o,
   output logic            pc_sel_o
);

   localparam int IN_BITS = OPW + FNW + 1;

   if (IN_BITS != 13) begin : g_bad_inputs
      $error("insn_ctrl_dec: decoder expects 13 input bits");
   end

   iclass_e         cls;
   logic [AOPW-1:0] aop;
   logic            fn_ok;
   ctrl_t           ctl;

   insn_class_dec #(.OPW(OPW)) u_cls (
      .op_i  (op_i),
      .cls_o (cls)
   );

   insn_alu_sel #(.FNW(FNW), .AOPW(AOPW)) u_alu (
      .cls_i    (cls),
      .fn_i     (fn_i),
      .alu_op_o (aop),
      .fn_ok_o  (fn_ok)
   );

   // control word assembly; don't-care fields stay at 0
   always_comb begin
      ctl = '0;
      unique case (cls)
         CLS_RR: begin
            if (fn_ok) begin
               ctl.reg_dst = 1'b1;
               ctl.reg_we  = 1'b1;
               ctl.alu_op  = aop;
            end
         end
         CLS_LOAD: begin
            ctl.reg_we     = 1'b1;
            ctl.alu_src    = 1'b1;
            ctl.alu_op     = aop;
            ctl.mem_re     = 1'b1;
            ctl.mem_to_reg = 1'b1;
         end
         CLS_STORE: begin
            ctl.alu_src = 1'b1;
            ctl.alu_op  = aop;
            ctl.mem_we  = 1'b1;
         end
         CLS_BRANCH: begin
            ctl.alu_op = aop;
            ctl.pc_sel = zero_i;
         end
         default: ctl = '0;
      endcase
   end

   assign reg_dst_o    = ctl.reg_dst;
   assign reg_we_o     = ctl.reg_we;
   assign alu_src_o    = ctl.alu_src;
   assign alu_op_o     = ctl.alu_op;
   assign mem_we_o     = ctl.mem_we;
   assign mem_re_o     = ctl.mem_re;
   assign mem_to_reg_o = ctl.mem_to_reg;
   assign pc_sel_o     = ctl.pc_sel;

endmodule

// File: rtl/insn_ctrl_chk.sv
module insn_ctrl_chk (
   input logic [5:0] op_i,
   input logic [5:0] fn_i,
   input logic       zero_i,
   input logic       reg_dst_o,
   input logic       reg_we_o,
   input logic       alu_src_o,
   input logic [2:0] alu_op_o,
   input logic       mem_we_o,
   input logic       mem_re_o,
   input logic       mem_to_reg_o,
   input logic       pc_sel_o
);

   logic known;
   logic op_listed;
   assign known     = !$isunknown({op_i, fn_i, zero_i});
   assign op_listed = (op_i == 6'b000000) || (op_i == 6'b100011) ||
                      (op_i == 6'b101011) || (op_i == 6'b000100);

   always_comb begin
      if (known) begin
         // R1 R2: destination from third field only for register-register writes
         p_rrdst_r1: assert (!reg_dst_o || (reg_we_o && !alu_src_o && op_i == 6'b000000))
            else $error("reg_dst_o without register-register write");
         // R4: memory writeback only for loads
         p_load_r4: assert (!mem_to_reg_o || (mem_re_o && reg_we_o && alu_src_o && alu_op_o == 3'b010))
            else $error("mem_to_reg_o outside a load");
         // R5: a store never writes the register file
         p_store_r5: assert (!mem_we_o || (!reg_we_o && !mem_re_o && alu_src_o && alu_op_o == 3'b010))
            else $error("store control inconsistent");
         // R7: branch taken only on the branch opcode with Zero set
         p_branch_r7: assert (pc_sel_o == (op_i == 6'b000100 && zero_i))
            else $error("pc_sel_o mismatch");
         // R8: unlisted opcodes are inert
         p_unknown_r8: assert (op_listed || {reg_dst_o, reg_we_o, alu_src_o, alu_op_o,
                                             mem_we_o, mem_re_o, mem_to_reg_o, pc_sel_o} == '0)
            else $error("unlisted opcode produced control");
         // R6: branch opcode never touches state other than the PC
         p_beq_r6: assert (op_i != 6'b000100 || (!reg_we_o && !mem_we_o && !mem_re_o && alu_op_o == 3'b110))
            else $error("branch control inconsistent");
      end
   end

endmodule

bind insn_ctrl_dec insn_ctrl_chk u_chk (
   .op_i         (op_i),
   .fn_i         (fn_i),
   .zero_i       (zero_i),
   .reg_dst_o    (reg_dst_o),
   .reg_we_o     (reg_we_o),
   .alu_src_o    (alu_src_o),
   .alu_op_o     (alu_op_o),
   .mem_we_o     (mem_we_o),
   .mem_re_o     (mem_re_o),
   .mem_to_reg_o (mem_to_reg_o),
   .pc_sel_o     (pc_sel_o)
);

// File: tb/insn_ctrl_dec_test.sv
module insn_ctrl_dec_test;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [5:0] op = '0;
   logic [5:0] fn = '0;
   logic       zero = 1'b0;
   logic       reg_dst, reg_we, alu_src, mem_we, mem_re, mem_to_reg, pc_sel;
   logic [2:0] alu_op;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   insn_ctrl_dec uut (
      .op_i         (op),
      .fn_i         (fn),
      .zero_i       (zero),
      .reg_dst_o    (reg_dst),
      .reg_we_o     (reg_we),
      .alu_src_o    (alu_src),
      .alu_op_o     (alu_op),
      .mem_we_o     (mem_we),
      .mem_re_o     (mem_re),
      .mem_to_reg_o (mem_to_reg),
      .pc_sel_o     (pc_sel)
   );

   // packed as {reg_dst, reg_we, alu_src, alu_op[2:0], mem_we, mem_re, mem_to_reg, pc_sel}
   function automatic logic [9:0] expect_word(input logic [5:0] o, input logic [5:0] f, input logic z);
      logic [2:0] a;
      case (o)
         6'd0: begin
            case (f)
               6'd32:   a = 3'd2;
               6'd34:   a = 3'd6;
               6'd36:   a = 3'd0;
               6'd37:   a = 3'd1;
               6'd42:   a = 3'd7;
               default: return 10'd0;
            endcase
            return {1'b1, 1'b1, 1'b0, a, 4'b0000};
         end
         6'd35:   return {1'b0, 1'b1, 1'b1, 3'd2, 1'b0, 1'b1, 1'b1, 1'b0};
         6'd43:   return {1'b0, 1'b0, 1'b1, 3'd2, 1'b1, 1'b0, 1'b0, 1'b0};
         6'd4:    return {1'b0, 1'b0, 1'b0, 3'd6, 3'b000, z};
         default: return 10'd0;
      endcase
   endfunction

   function automatic string tag_for(input logic [5:0] o, input logic [5:0] f, input logic z);
      if (o == 6'd4) return z ? "R7" : "R6";
      if ((o == 6'd35 || o == 6'd43) && f != 6'd0) return "R9";
      if (o != 6'd0 && z) return "R10";
      case (o)
         6'd0:    return (f == 6'd32) ? "R1" :
                         (f == 6'd34 || f == 6'd36 || f == 6'd37 || f == 6'd42) ? "R2" : "R3";
         6'd35:   return "R4";
         6'd43:   return "R5";
         default: return "R8";
      endcase
   endfunction

   task automatic check_one(input logic [5:0] o, input logic [5:0] f, input logic z, input string tag);
      logic [9:0] got, exp;
      @(posedge clk);
      op = o; fn = f; zero = z;
      @(negedge clk);
      got = {reg_dst, reg_we, alu_src, alu_op, mem_we, mem_re, mem_to_reg, pc_sel};
      exp = expect_word(o, f, z);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s op=%b fn=%b zero=%b actual=%b expected=%b", tag, o, f, z, got, exp);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // reset state: all-zero inputs are an unlisted function code (R3)
      check_one(6'd0, 6'd0, 1'b0, "R3");
      // directed boundary cases
      check_one(6'd0, 6'd32, 1'b1, "R1");
      check_one(6'd0, 6'd42, 1'b0, "R2");
      check_one(6'd4, 6'd63, 1'b1, "R7");
      check_one(6'd4, 6'd63, 1'b0, "R6");
      check_one(6'd63, 6'd32, 1'b1, "R8");
      // exhaustive sweep of opcode, function field and Zero
      for (int o = 0; o < 64; o++)
         for (int f = 0; f < 64; f++)
            for (int z = 0; z < 2; z++)
               check_one(6'(o), 6'(f), 1'(z), tag_for(6'(o), 6'(f), 1'(z)));
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=hung expected=complete");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule